// File: doc/BRIEF.md
# DMA Completion Interrupt Coalescer

This block sits next to one DMA channel, either the transmit or the receive side, and limits how often that channel interrupts the processor. Every finished packet arrives as a one-cycle completion strobe. The block counts these strobes and raises its interrupt only when one of two conditions is met. The first is that a programmed number of completions has built up. The second is that a wait bound, measured in timebase ticks from the first completion still waiting, has run out. Whichever condition comes first wins. An error strobe skips coalescing and flags at once.

Software configures the block through one 32-bit control word. That word holds the run flag, a self-clearing soft reset, three interrupt enables, the completion threshold and the wait bound. Software reads the three event flags from a status word and clears them by writing ones. The interrupt output is a level signal. It stays high while any enabled flag is set.

Top module: `irq_coalesce`

## Requirements
- R1: After reset the control word reads 0xFE180000, which is a wait bound of 254 in bits 31:24 and a threshold of 24 in bits 23:16, with all other bits clear. The status word reads 0 and `irq` is low.
- R2: While control bit 0 (run) is set, each `done_pulse` adds one to an internal count. On the clock edge where the count reaches the threshold in control bits 23:16, status bit 12 sets and the count returns to zero.
- R3: The first completion after the count is empty arms a timer. A `tick` in a later cycle advances the timer by one. On the edge of the Nth such tick, where N is control bits 31:24, status bit 13 sets and both the count and the timer return to zero. The timer does not advance while the count is empty.
- R4: A wait bound of 0 disables the timeout. Any number of ticks then leaves bit 13 clear, and the count keeps building toward the threshold.
- R5: A threshold field of 0 acts as a threshold of 1.
- R6: An `err_pulse` sets status bit 14 on the same edge, whatever the run flag and the count are.
- R7: Writing the status word clears each of bits 12, 13 and 14 that is written as 1. If an event sets a bit in the same cycle as the write clears it, the bit ends up set.
- R8: `irq` is high exactly when some status bit among 12, 13 and 14 is set and the enable bit at the same position in the control word is also set. A flag that is set but masked leaves `irq` low.
- R9: While run is clear, completion strobes and ticks are ignored and the count is held.
- R10: Writing control bit 2 starts a soft reset. Bit 2 reads back as 1 for one cycle. On the next edge, bits 2 and 0, the status word, the count and the timer all clear, and the threshold, wait bound and enables keep their values. A control write made during that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Write `wdata` into the control word. Only bits 0, 2, 12-14 and 16-31 are stored |
| stat_we | input | 1 | Write-one-to-clear access to the status word using `wdata` |
| wdata | input | 32 | Write data for either word |
| done_pulse | input | 1 | One-cycle completion strobe |
| err_pulse | input | 1 | One-cycle error strobe |
| tick | input | 1 | Timebase strobe for the wait-bound timer |
| ctrl_rdata | output | 32 | Current control word |
| stat_rdata | output | 32 | Status word. Flags sit in bits 14:12 |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after the boundaries of the two counters and the cases where two events meet in one cycle.

- **Threshold boundary.** The completion flag must appear exactly on the Nth strobe. A count that is off by one, or that is not reloaded after firing, shifts the flag by a strobe, and the next batch misses its edge.
- **Timeout boundary.** The timeout must land on the Nth tick. A zero bound must never fire. A timer that runs while the count is empty would raise a spurious timeout.
- **Threshold of zero.** A threshold of zero must fire on one strobe. A design that misses this either hangs or fires after 256 strobes.
- **Set against clear.** An error that arrives together with a write-one-to-clear must survive.
- **Soft reset.** After a soft reset the stale count must be gone. If it remained, a later batch would complete one strobe early.

// File: rtl/irq_coalesce_pkg.sv
package irq_coalesce_pkg;

    localparam int WORD_W   = 32;
    localparam int FIELD_W  = 8;
    localparam int RUN_BIT  = 0;
    localparam int SRST_BIT = 2;
    localparam int EVT_LSB  = 12;
    localparam int N_EVT    = 3;
    localparam int THR_LSB  = 16;
    localparam int DLY_LSB  = 24;

    typedef enum logic [1:0] {
        EV_CMP = 2'd0,
        EV_TMO = 2'd1,
        EV_ERR = 2'd2
    } evt_idx_e;

    typedef struct packed {
        logic [FIELD_W-1:0] dly;
        logic [FIELD_W-1:0] thr;
        logic [N_EVT-1:0]   en;
        logic               srst;
        logic               run;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(logic [WORD_W-1:0] w);
        ctrl_t c;
        c.dly  = w[DLY_LSB +: FIELD_W];
        c.thr  = w[THR_LSB +: FIELD_W];
        c.en   = w[EVT_LSB +: N_EVT];
        c.srst = w[SRST_BIT];
        c.run  = w[RUN_BIT];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        m[RUN_BIT]  = 1'b1;
        m[SRST_BIT] = 1'b1;
        m[EVT_LSB +: N_EVT]  = '1;
        m[THR_LSB +: FIELD_W] = '1;
        m[DLY_LSB +: FIELD_W] = '1;
        return m;
    endfunction

endpackage

// File: rtl/irq_coal_regs.sv
module irq_coal_regs
    import irq_coalesce_pkg::*;
#(
    parameter logic [FIELD_W-1:0] THR_RST = 8'd24,
    parameter logic [FIELD_W-1:0] DLY_RST = 8'd254
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] ctrl_q
);
    localparam logic [WORD_W-1:0] RST_WORD =
        (WORD_W'(DLY_RST) << DLY_LSB) | (WORD_W'(THR_RST) << THR_LSB);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= RST_WORD;
        end else if (ctrl_q[SRST_BIT]) begin
            ctrl_q[SRST_BIT] <= 1'b0;
            ctrl_q[RUN_BIT]  <= 1'b0;
        end else if (wr_en) begin
            ctrl_q <= wdata & ctrl_mask();
        end
    end
endmodule

// File: rtl/irq_coal_engine.sv
module irq_coal_engine
    import irq_coalesce_pkg::*;
#(
    parameter int CNT_W = FIELD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic [CNT_W-1:0] thr,
    input  logic [CNT_W-1:0] dly,
    input  logic             done,
    input  logic             tick,
    output logic             hit_cmp,
    output logic             hit_tmo
);
    logic [CNT_W-1:0] cnt, tmr;
    logic             armed;
    logic [CNT_W-1:0] thr_eff;
    logic [CNT_W:0]   cnt_sum, tmr_sum;
    logic             done_v, tick_v;

    always_comb begin
        thr_eff = (thr == '0) ? CNT_W'(1) : thr;
        done_v  = run & done;
        tick_v  = run & tick & armed;
        cnt_sum = {1'b0, cnt} + (CNT_W+1)'(done_v);
        tmr_sum = {1'b0, tmr} + (CNT_W+1)'(1);
        hit_cmp = done_v && (cnt_sum >= {1'b0, thr_eff});
        hit_tmo = !hit_cmp && tick_v && (dly != '0) && (tmr_sum >= {1'b0, dly});
    end

    always_ff @(posedge clk) begin
        if (rst || clr || hit_cmp) begin
            cnt   <= '0;
            tmr   <= '0;
            armed <= 1'b0;
        end else if (hit_tmo) begin
            cnt   <= CNT_W'(done_v);
            tmr   <= '0;
            armed <= done_v;
        end else begin
            cnt   <= cnt_sum[CNT_W-1:0];
            armed <= armed | done_v;
            if (tick_v) tmr <= tmr_sum[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/irq_coal_status.sv
module irq_coal_status
    import irq_coalesce_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [N_EVT-1:0] set_vec,
    input  logic             w1c_we,
    input  logic [N_EVT-1:0] w1c_bits,
    input  logic [N_EVT-1:0] en,
    output logic [N_EVT-1:0] stat_q,
    output logic             irq
);
    logic [N_EVT-1:0] clr_vec;

    always_comb begin
        clr_vec = w1c_we ? w1c_bits : '0;
        irq     = |(stat_q & en);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) stat_q <= '0;
        else            stat_q <= (stat_q & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
    import irq_coalesce_pkg::*;
#(
    parameter logic [FIELD_W-1:0] THR_RST = 8'd24,
    parameter logic [FIELD_W-1:0] DLY_RST = 8'd254
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic              stat_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              done_pulse,
    input  logic              err_pulse,
    input  logic              tick,
    output logic [WORD_W-1:0] ctrl_rdata,
    output logic [WORD_W-1:0] stat_rdata,
    output logic              irq
);
    logic [WORD_W-1:0] ctrl_q;
    ctrl_t             cfg;
    logic              hit_cmp, hit_tmo;
    logic [N_EVT-1:0]  set_vec, stat_q;

    irq_coal_regs #(.THR_RST(THR_RST), .DLY_RST(DLY_RST)) u_regs (
        .clk(clk), .rst(rst), .wr_en(ctrl_we), .wdata(wdata), .ctrl_q(ctrl_q)
    );

    assign cfg = ctrl_unpack(ctrl_q);

    irq_coal_engine #(.CNT_W(FIELD_W)) u_engine (
        .clk(clk), .rst(rst), .clr(cfg.srst), .run(cfg.run),
        .thr(cfg.thr), .dly(cfg.dly), .done(done_pulse), .tick(tick),
        .hit_cmp(hit_cmp), .hit_tmo(hit_tmo)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[EV_CMP] = hit_cmp;
        set_vec[EV_TMO] = hit_tmo;
        set_vec[EV_ERR] = err_pulse;
    end

    irq_coal_status u_status (
        .clk(clk), .rst(rst), .clr(cfg.srst), .set_vec(set_vec),
        .w1c_we(stat_we), .w1c_bits(wdata[EVT_LSB +: N_EVT]), .en(cfg.en),
        .stat_q(stat_q), .irq(irq)
    );

    always_comb begin
        stat_rdata = '0;
        stat_rdata[EVT_LSB +: N_EVT] = stat_q;
    end
    assign ctrl_rdata = ctrl_q;
endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk (
    input logic        clk,
    input logic        rst,
    input logic        done_pulse,
    input logic        err_pulse,
    input logic        tick,
    input logic [31:0] ctrl_rdata,
    input logic [31:0] stat_rdata,
    input logic        irq
);
    // R2
    cmp_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_rdata[12]) |-> $past(done_pulse));

    // R3
    tmo_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_rdata[13]) |-> $past(tick));

    // R6
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        (err_pulse && !ctrl_rdata[2]) |=> stat_rdata[14]);

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rdata[14:12] == 3'b000) |-> !irq);

    // R9
    stopped_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_rdata[0] |=> !$rose(stat_rdata[12]));

    // R10
    sreset_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_rdata[2] |=> (!ctrl_rdata[2] && !ctrl_rdata[0] && stat_rdata[14:12] == 3'b000));
endmodule

bind irq_coalesce irq_coalesce_chk u_chk (
    .clk(clk), .rst(rst), .done_pulse(done_pulse), .err_pulse(err_pulse),
    .tick(tick), .ctrl_rdata(ctrl_rdata), .stat_rdata(stat_rdata), .irq(irq)
);

// File: tb/irq_coalesce_bench.sv
`timescale 1ns/1ps
module irq_coalesce_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0, stat_we = 1'b0;
    logic [31:0] wdata = '0;
    logic        done_pulse = 1'b0, err_pulse = 1'b0, tick = 1'b0;
    logic [31:0] ctrl_rdata, stat_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        string       req;
        bit          use_ctrl;
        logic [31:0] ctrl;
        logic [31:0] stat;
        logic        irq;
    } exp_t;
    exp_t sb_q[$];
    event mon_ev;

    always #5 clk = ~clk;

    irq_coalesce u_irq_coalesce (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .stat_we(stat_we), .wdata(wdata),
        .done_pulse(done_pulse), .err_pulse(err_pulse), .tick(tick),
        .ctrl_rdata(ctrl_rdata), .stat_rdata(stat_rdata), .irq(irq)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                n_chk++;
                if (stat_rdata !== it.stat || irq !== it.irq ||
                    (it.use_ctrl && ctrl_rdata !== it.ctrl)) begin
                    n_fail++;
                    $display("FAIL %s: stat=%h irq=%b ctrl=%h expected stat=%h irq=%b ctrl=%h",
                             it.req, stat_rdata, irq, ctrl_rdata, it.stat, it.irq,
                             it.use_ctrl ? it.ctrl : ctrl_rdata);
                end
            end
        end
    end

    // driver: one clock with the given strobes, then release
    task automatic cyc(bit cw, bit sw, logic [31:0] d, bit dn, bit er, bit tk);
        ctrl_we = cw; stat_we = sw; wdata = d;
        done_pulse = dn; err_pulse = er; tick = tk;
        @(posedge clk); #1;
        ctrl_we = 0; stat_we = 0; wdata = '0;
        done_pulse = 0; err_pulse = 0; tick = 0;
    endtask

    task automatic expect_st(string req, logic [31:0] st, logic ir);
        exp_t it;
        it.req = req; it.use_ctrl = 0; it.ctrl = '0; it.stat = st; it.irq = ir;
        sb_q.push_back(it);
        -> mon_ev;
        #1;
    endtask

    task automatic expect_all(string req, logic [31:0] c, logic [31:0] st, logic ir);
        exp_t it;
        it.req = req; it.use_ctrl = 1; it.ctrl = c; it.stat = st; it.irq = ir;
        sb_q.push_back(it);
        -> mon_ev;
        #1;
    endtask

    task automatic dones(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, '0, 1, 0, 0);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, '0, 0, 0, 1);
    endtask

    initial begin
        #20000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset values
        expect_all("R1 reset", 32'hFE18_0000, 32'h0, 1'b0);

        // R2 threshold 3, all enables, run
        cyc(1, 0, 32'h0003_7001, 0, 0, 0);
        expect_all("R2 ctrl write", 32'h0003_7001, 32'h0, 1'b0);
        dones(2);
        expect_st("R2 below threshold", 32'h0, 1'b0);
        dones(1);
        expect_st("R2 threshold reached", 32'h1000, 1'b1);

        // R7 write one to clear
        cyc(0, 1, 32'h0000_1000, 0, 0, 0);
        expect_st("R7 clear completion flag", 32'h0, 1'b0);

        // R4 zero wait bound never times out
        dones(1);
        ticks(300);
        expect_st("R4 no timeout with zero bound", 32'h0, 1'b0);
        dones(2);
        expect_st("R4 count kept across ticks", 32'h1000, 1'b1);
        cyc(0, 1, 32'h0000_7000, 0, 0, 0);

        // R3 timeout after 5 ticks, threshold 10
        cyc(1, 0, 32'h050A_7001, 0, 0, 0);
        dones(1);
        ticks(4);
        expect_st("R3 before bound", 32'h0, 1'b0);
        ticks(1);
        expect_st("R3 timeout on bound", 32'h2000, 1'b1);
        cyc(0, 1, 32'h0000_2000, 0, 0, 0);
        dones(9);
        expect_st("R3 count cleared by timeout", 32'h0, 1'b0);
        dones(1);
        expect_st("R3 full batch after timeout", 32'h1000, 1'b1);
        cyc(0, 1, 32'h0000_1000, 0, 0, 0);
        ticks(20);
        expect_st("R3 timer idle while empty", 32'h0, 1'b0);

        // R5 threshold zero acts as one
        cyc(1, 0, 32'h0000_7001, 0, 0, 0);
        dones(1);
        expect_st("R5 zero threshold", 32'h1000, 1'b1);
        cyc(0, 1, 32'h0000_1000, 0, 0, 0);

        // R9 stopped channel ignores completions
        cyc(1, 0, 32'h0000_7000, 0, 0, 0);
        dones(3);
        expect_st("R9 stopped ignores done", 32'h0, 1'b0);

        // R6 error while stopped; R7 set wins over same-cycle clear
        cyc(0, 1, 32'h0000_4000, 0, 1, 0);
        expect_st("R6 R7 error set beats clear", 32'h4000, 1'b1);
        cyc(0, 1, 32'h0000_4000, 0, 0, 0);
        expect_st("R7 clear error flag", 32'h0, 1'b0);

        // R8 masking
        cyc(1, 0, 32'h0003_0001, 0, 0, 0);
        dones(3);
        expect_st("R8 masked flag keeps irq low", 32'h1000, 1'b0);
        cyc(1, 0, 32'h0003_1001, 0, 0, 0);
        expect_st("R8 enabling raises irq", 32'h1000, 1'b1);
        cyc(0, 1, 32'h0000_1000, 0, 0, 0);

        // R10 soft reset
        cyc(1, 0, 32'h0003_7001, 0, 0, 0);
        dones(2);
        cyc(0, 0, '0, 0, 1, 0);
        expect_st("R10 setup", 32'h4000, 1'b1);
        cyc(1, 0, 32'h0003_7005, 0, 0, 0);
        expect_all("R10 reset bit visible", 32'h0003_7005, 32'h4000, 1'b1);
        cyc(1, 0, 32'hFFFF_7001, 0, 0, 0);
        expect_all("R10 self clear and write ignored", 32'h0003_7000, 32'h0, 1'b0);
        cyc(1, 0, 32'h0003_7001, 0, 0, 0);
        dones(2);
        expect_st("R10 stale count gone", 32'h0, 1'b0);
        dones(1);
        expect_st("R10 fresh batch completes", 32'h1000, 1'b1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule